// File: doc/BRIEF.md
# Dual-Mode Compare-Match PWM Timer

This block is one timer channel. It has a free-running up-counter and four compare registers, named A, B, C and D. Together they generate pulse-width-modulated waveforms on four output pins. Any one of the compare registers can be chosen as the source that reloads the counter, and that register then sets the waveform period. When the counter equals a compare register, the control field of that register decides what happens to the pin. The pin can be driven low, driven high, toggled or left alone.

The channel has two ways of using its registers. In paired mode, A and B shape the waveform on pin 0, and C and D shape the waveform on pin 2. In period mode, the clear-source register is shared as the period. Every other register then acts as a duty value for its own pin, and each counter reload returns that pin to its start level. In both modes, two equal compare values produce no edge at all, so a steady 0 % or 100 % level can be programmed. Software writes the configuration through a small address/data port. The configuration can also be written while reset is held, so that the pins come out of reset at the programmed levels.

Top module: `pwm_cm_timer`

## Requirements
- R1: When `cnt_en` is high, the counter advances by one on each clock edge. When `cnt_en` is low, the counter holds its value.
- R2: `clr_sel` picks the clear source (0=A, 1=B, 2=C, 3=D). On the enabled edge where the counter equals that register, the counter goes to 0, so the period is that value plus one.
- R3: Writes with `wr_addr` 0..3 load compare registers A..D. Writes with `wr_addr` 4..7 load the control field of A..D. In a control field, `wr_data[1:0]` selects the match action (00 keep, 01 drive 0, 10 drive 1, 11 toggle) and `wr_data[2]` is the start level.
- R4: A pin changes on the same edge at which the counter leaves the matching value. While `cnt_en` is low, no compare match is taken.
- R5: With `mode_sel`=0, the matches of A and B act on pin 0 and the matches of C and D act on pin 2. Pins 1 and 3 hold the start levels of B and D.
- R6: With `mode_sel`=0, the start level of pin 0 comes from the control field of A, and the start level of pin 2 comes from the control field of C.
- R7: With `mode_sel`=0, if both registers of a pair hold equal values, the pin of that pair never changes.
- R8: With `mode_sel`=1, the clear-source register is the period. Each other register drives the pin with its own index, using its own action.
- R9: With `mode_sel`=1, a counter reload puts each duty pin back to its start level. This takes priority over that pin's duty match in the same cycle.
- R10: With `mode_sel`=1, the pin of the period register holds its own start level.
- R11: With `mode_sel`=1, a duty register equal to the period register leaves its pin unchanged.
- R12: A synchronous `rst` clears the counter and loads every pin with its start level. Configuration writes are accepted during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Write target: 0..3 compare A..D, 4..7 control A..D |
| wr_data | input | CNT_W | Write data |
| mode_sel | input | 1 | 0 = paired mode, 1 = period mode |
| clr_sel | input | 2 | Clear-source register select |
| cnt_en | input | 1 | Count enable |
| pwm_out | output | 4 | Output pins 0..3 |
| cnt_out | output | CNT_W | Current counter value |

## Verification
Some behaviour is checked on every cycle by the assertions. These checks cover the counter step and hold, the reload to zero after a clear-source match, and the fixed levels on the spare pins in paired mode. They also cover the suppression of edges when a pair or a duty/period pair holds equal values, and the return of duty pins and the period pin to their start levels in period mode. The bench scenarios show the complete waveform shapes. These include the exact edge at which each action lands, how drive-low, drive-high and toggle combine over several periods, and the start levels after a reset issued in the middle of a run. They also show that a paused counter freezes both the count and the pins.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  localparam int NUM_CMP = 4;
  localparam int SEL_W   = 2;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  typedef enum logic {
    MODE_PAIRED = 1'b0,
    MODE_PERIOD = 1'b1
  } mode_e;

  typedef struct packed {
    logic start_lvl;
    act_e act;
  } ioctl_t;

  // R3: level a pin takes when the match action is applied to its current level
  function automatic logic apply_act(input logic cur, input act_e act);
    logic res;
    unique case (act)
      ACT_KEEP:   res = cur;
      ACT_LOW:    res = 1'b0;
      ACT_HIGH:   res = 1'b1;
      ACT_TOGGLE: res = ~cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/pwmt_cfg_regs.sv
module pwmt_cfg_regs
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cmp_q   [NUM_CMP],
  output ioctl_t           ioctl_q [NUM_CMP]
);

  // R3, R12: storage is only touched by the write port, so it survives reset
  for (genvar k = 0; k < NUM_CMP; k++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_addr[SEL_W-1:0] == SEL_W'(k));

    always_ff @(posedge clk) begin
      if (hit && !wr_addr[2]) cmp_q[k] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (hit && wr_addr[2]) ioctl_q[k] <= ioctl_t'(wr_data[2:0]);
    end
  end

endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             clear_hit,
  output logic [CNT_W-1:0] cnt_q
);

  // R1, R2: step by one, or reload when the clear source matched
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic reload);
    return reload ? '0 : cur + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (cnt_en) cnt_q <= next_count(cnt_q, clear_hit);
  end

endmodule

// File: rtl/pwmt_compare.sv
module pwmt_compare
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0]       cnt_q,
  input  logic                   cnt_en,
  input  logic [CNT_W-1:0]       cmp_q [NUM_CMP],
  input  logic [SEL_W-1:0]       clr_sel,
  output logic [NUM_CMP-1:0]     match_vec,
  output logic [NUM_CMP-1:0]     eq_period,
  output logic [NUM_CMP/2-1:0]   pair_eq,
  output logic                   clear_hit
);

  logic [CNT_W-1:0] period_val;
  assign period_val = cmp_q[clr_sel];

  // R4: matches only count on enabled cycles
  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    assign match_vec[k] = cnt_en && (cnt_q == cmp_q[k]);
    assign eq_period[k] = (cmp_q[k] == period_val);
  end

  for (genvar j = 0; j < NUM_CMP/2; j++) begin : g_pair
    assign pair_eq[j] = (cmp_q[2*j] == cmp_q[2*j+1]);
  end

  assign clear_hit = match_vec[clr_sel];

endmodule

// File: rtl/pwmt_out_ctrl.sv
module pwmt_out_ctrl
  import pwmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  mode_e                mode,
  input  logic [SEL_W-1:0]     clr_sel,
  input  logic [NUM_CMP-1:0]   match_vec,
  input  logic [NUM_CMP-1:0]   eq_period,
  input  logic [NUM_CMP/2-1:0] pair_eq,
  input  logic                 clear_hit,
  input  ioctl_t               ioctl_q [NUM_CMP],
  output logic [NUM_CMP-1:0]   pwm_q
);

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_pin
    localparam bit IS_LEAD = (k % 2 == 0);
    localparam int PARTNER = IS_LEAD ? k + 1 : k;

    logic nxt;
    logic own_start;
    assign own_start = ioctl_q[k].start_lvl;

    always_comb begin
      nxt = pwm_q[k];
      if (mode == MODE_PAIRED) begin
        if (!IS_LEAD) begin
          nxt = own_start;                                   // R5
        end else if (!pair_eq[k/2]) begin                    // R7
          if (match_vec[k])
            nxt = apply_act(pwm_q[k], ioctl_q[k].act);
          else if (match_vec[PARTNER])
            nxt = apply_act(pwm_q[k], ioctl_q[PARTNER].act);
        end
      end else begin
        if (clr_sel == SEL_W'(k)) begin
          nxt = own_start;                                   // R10
        end else if (eq_period[k]) begin
          nxt = pwm_q[k];                                    // R11
        end else if (clear_hit) begin
          nxt = own_start;                                   // R9
        end else if (match_vec[k]) begin
          nxt = apply_act(pwm_q[k], ioctl_q[k].act);         // R8
        end
      end
    end

    // R12, R6: reset loads the pin's own start level
    always_ff @(posedge clk) begin
      if (rst) pwm_q[k] <= own_start;
      else     pwm_q[k] <= nxt;
    end
  end

endmodule

// File: rtl/pwm_cm_timer.sv
module pwm_cm_timer
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             mode_sel,
  input  logic [1:0]       clr_sel,
  input  logic             cnt_en,
  output logic [3:0]       pwm_out,
  output logic [CNT_W-1:0] cnt_out
);

  logic [CNT_W-1:0]     cmp_q   [NUM_CMP];
  ioctl_t               ioctl_q [NUM_CMP];
  logic [CNT_W-1:0]     cnt_q;
  logic [NUM_CMP-1:0]   match_vec;
  logic [NUM_CMP-1:0]   eq_period;
  logic [NUM_CMP/2-1:0] pair_eq;
  logic                 clear_hit;
  logic [NUM_CMP-1:0]   start_vec;
  mode_e                mode;

  assign mode = mode_e'(mode_sel);

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_start
    assign start_vec[k] = ioctl_q[k].start_lvl;
  end

  pwmt_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cmp_q   (cmp_q),
    .ioctl_q (ioctl_q)
  );

  pwmt_compare #(.CNT_W(CNT_W)) u_cmp (
    .cnt_q     (cnt_q),
    .cnt_en    (cnt_en),
    .cmp_q     (cmp_q),
    .clr_sel   (clr_sel),
    .match_vec (match_vec),
    .eq_period (eq_period),
    .pair_eq   (pair_eq),
    .clear_hit (clear_hit)
  );

  pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (cnt_en),
    .clear_hit (clear_hit),
    .cnt_q     (cnt_q)
  );

  pwmt_out_ctrl u_out (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .clr_sel   (clr_sel),
    .match_vec (match_vec),
    .eq_period (eq_period),
    .pair_eq   (pair_eq),
    .clear_hit (clear_hit),
    .ioctl_q   (ioctl_q),
    .pwm_q     (pwm_out)
  );

  assign cnt_out = cnt_q;

endmodule

// File: rtl/pwm_cm_timer_chk.sv
module pwm_cm_timer_chk
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               cnt_en,
  input logic               mode_sel,
  input logic [1:0]         clr_sel,
  input logic               clear_hit,
  input logic [CNT_W-1:0]   cnt_q,
  input logic [CNT_W-1:0]   cmp_q [NUM_CMP],
  input logic [NUM_CMP-1:0] start_vec,
  input logic [3:0]         pwm_out
);

  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !clear_hit) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  a_r1_count_hold: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(cnt_q));

  a_r2_reload: assert property (@(posedge clk) disable iff (rst)
    clear_hit |=> (cnt_q == '0));

  a_r5_spare_pins: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 1'b0) |=> (pwm_out[1] == $past(start_vec[1]) &&
                            pwm_out[3] == $past(start_vec[3])));

  a_r7_equal_pair_ab: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 1'b0 && cmp_q[0] == cmp_q[1]) |=> $stable(pwm_out[0]));

  a_r7_equal_pair_cd: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 1'b0 && cmp_q[2] == cmp_q[3]) |=> $stable(pwm_out[2]));

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_pin_chk
    a_r9_reload_restores: assert property (@(posedge clk) disable iff (rst)
      (mode_sel == 1'b1 && clear_hit && clr_sel != 2'(k) &&
       cmp_q[k] != cmp_q[clr_sel]) |=> (pwm_out[k] == $past(start_vec[k])));

    a_r10_period_pin: assert property (@(posedge clk) disable iff (rst)
      (mode_sel == 1'b1 && clr_sel == 2'(k)) |=> (pwm_out[k] == $past(start_vec[k])));

    a_r11_equal_duty: assert property (@(posedge clk) disable iff (rst)
      (mode_sel == 1'b1 && clr_sel != 2'(k) && cmp_q[k] == cmp_q[clr_sel])
        |=> $stable(pwm_out[k]));
  end

endmodule

bind pwm_cm_timer pwm_cm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_en    (cnt_en),
  .mode_sel  (mode_sel),
  .clr_sel   (clr_sel),
  .clear_hit (clear_hit),
  .cnt_q     (cnt_q),
  .cmp_q     (cmp_q),
  .start_vec (start_vec),
  .pwm_out   (pwm_out)
);

// File: tb/pwm_cm_timer_tb_top.sv
module pwm_cm_timer_tb_top;
  import pwmt_pkg::*;

  localparam int W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         mode_sel = 1'b0;
  logic [1:0]   clr_sel = '0;
  logic         cnt_en = 1'b0;
  logic [3:0]   pwm_out;
  logic [W-1:0] cnt_out;

  pwm_cm_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_sel(mode_sel), .clr_sel(clr_sel), .cnt_en(cnt_en),
    .pwm_out(pwm_out), .cnt_out(cnt_out)
  );

  typedef struct packed {
    logic [W-1:0] cnt;
    logic [3:0]   pins;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  function automatic logic [W-1:0] ctl(input logic lvl, input act_e a);
    return W'({lvl, a});
  endfunction

  // period (reload value + 1) of each scenario
  function automatic int period_of(input int s);
    case (s)
      1: return 10;
      2: return 8;
      3: return 10;
      default: return 6;
    endcase
  endfunction

  // Expected pins after e enabled edges, from the programmed values
  function automatic logic [3:0] exp_pins(input int s, input int e);
    int m;
    logic [3:0] p;
    m = (e + period_of(s) - 1) % period_of(s);   // last count seen
    case (s)
      1: begin
        if (e == 0) return 4'b1011;
        p[0] = 1'b1;                     // R10 period pin
        p[1] = !(m >= 3 && m <= 8);      // R8 low at 3, R9 back at reload
        p[2] = (m >= 6 && m <= 8);       // R8 high at 6, R9 back at reload
        p[3] = 1'b1;                     // duty beyond period: never matches
      end
      2: begin
        if (e == 0) return 4'b0110;
        p[0] = (e >= 8) && (m == 7 || m < 2);  // R5 high at 7, low at 2
        p[1] = 1'b1;
        p[2] = !(m == 3 || m == 4);            // toggles at 3 and 5
        p[3] = 1'b0;
      end
      3: begin
        if (e == 0) return 4'b1001;
        p[0] = 1'b1;                     // R7 A==B
        p[1] = 1'b0;
        p[2] = (m >= 2 && m <= 8);
        p[3] = 1'b1;
      end
      default: begin
        if (e == 0) return 4'b1010;
        p[0] = 1'b0;                     // R11 A==period
        p[1] = 1'b1;                     // R10
        p[2] = (m >= 2 && m <= 4);
        p[3] = (m == 5);                 // R9 reload over duty at 0
      end
    endcase
    return p;
  endfunction

  task automatic push(input int s, input int e, input string tag);
    exp_t x;
    x.cnt  = W'(e % period_of(s));
    x.pins = exp_pins(s, e);
    exp_q.push_back(x);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
  endtask

  task automatic run_scen(input int s, input int steps, input int pause_at,
                          input int pause_len, input string tag);
    int e;
    e = 0;
    @(negedge clk);
    rst = 1'b1;
    cnt_en = 1'b0;
    case (s)
      1: begin
        mode_sel = 1'b1; clr_sel = 2'd0;
        wr(3'd0, W'(9)); wr(3'd1, W'(3)); wr(3'd2, W'(6)); wr(3'd3, W'(12));
        wr(3'd4, ctl(1'b1, ACT_TOGGLE)); wr(3'd5, ctl(1'b1, ACT_LOW));
        wr(3'd6, ctl(1'b0, ACT_HIGH));   wr(3'd7, ctl(1'b1, ACT_TOGGLE));
      end
      2: begin
        mode_sel = 1'b0; clr_sel = 2'd0;
        wr(3'd0, W'(7)); wr(3'd1, W'(2)); wr(3'd2, W'(3)); wr(3'd3, W'(5));
        wr(3'd4, ctl(1'b0, ACT_HIGH));   wr(3'd5, ctl(1'b1, ACT_LOW));
        wr(3'd6, ctl(1'b1, ACT_TOGGLE)); wr(3'd7, ctl(1'b0, ACT_TOGGLE));
      end
      3: begin
        mode_sel = 1'b0; clr_sel = 2'd3;
        wr(3'd0, W'(4)); wr(3'd1, W'(4)); wr(3'd2, W'(2)); wr(3'd3, W'(9));
        wr(3'd4, ctl(1'b1, ACT_TOGGLE)); wr(3'd5, ctl(1'b0, ACT_LOW));
        wr(3'd6, ctl(1'b0, ACT_HIGH));   wr(3'd7, ctl(1'b1, ACT_LOW));
      end
      default: begin
        mode_sel = 1'b1; clr_sel = 2'd1;
        wr(3'd0, W'(5)); wr(3'd1, W'(5)); wr(3'd2, W'(2)); wr(3'd3, W'(0));
        wr(3'd4, ctl(1'b0, ACT_TOGGLE)); wr(3'd5, ctl(1'b1, ACT_TOGGLE));
        wr(3'd6, ctl(1'b0, ACT_HIGH));   wr(3'd7, ctl(1'b1, ACT_LOW));
      end
    endcase
    @(negedge clk);
    wr_en = 1'b0;
    @(posedge clk);
    push(s, 0, (s == 2 || s == 3) ? "R12 R6 reset levels" : "R12 reset levels");
    @(negedge clk);
    rst = 1'b0;
    cnt_en = 1'b1;
    for (int i = 0; i < steps; i++) begin
      @(posedge clk);
      if (cnt_en) e++;
      push(s, e, cnt_en ? tag : "R1 R4 paused");
      @(negedge clk);
      cnt_en = !((i + 1) >= pause_at && (i + 1) < pause_at + pause_len);
    end
  endtask

  // Monitor: pops expectations and compares away from the edge
  initial begin
    exp_t  x;
    string t;
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        x = exp_q.pop_front();
        t = tag_q.pop_front();
        n_run++;
        if (cnt_out !== x.cnt || pwm_out !== x.pins) begin
          n_fail++;
          $display("FAIL %s: cnt=%0d pins=%b expected cnt=%0d pins=%b",
                   t, cnt_out, pwm_out, x.cnt, x.pins);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    run_scen(1, 30, 13, 3, "R1 R2 R3 R4 R8 R9 R10");
    run_scen(2, 28, 100, 0, "R1 R2 R3 R4 R5");
    run_scen(3, 25, 100, 0, "R2 R3 R5 R7");
    run_scen(4, 20, 7, 2, "R2 R3 R8 R9 R10 R11");
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule